// File: doc/BRIEF.md
# Tuner PLL serial control slave

This block is the digital front end of a satellite tuner synthesizer. It is a two-wire serial slave that answers one 7-bit device address. The upper five address bits are fixed, and the lower two come from strap pins. A write transfer programs three register groups: a 15-bit loop divider ratio, a control group (charge-pump current, test mode, reference divider select and an oscillator disable), and a band-switch group that drives port outputs. A read transfer returns one status byte that reports a sticky power-on flag, the loop lock indication and three comparator levels.

The SCL and SDA lines are oversampled by the system clock through a synchronizer. START and STOP conditions are detected inside the block, and SDA is pulled low through an open-drain enable. The divider ratio spans two bytes. It reaches its output only when the acknowledge of the second byte completes, so a half-written ratio is never applied. A byte that has not finished its acknowledge when a START or STOP interrupts the transfer is discarded. The analog loop, the comparators and the pad drivers sit outside this block, and lock and comparator levels arrive as digital inputs.

Top module: `tuner_ctl_slave`

## Requirements
- R1: The block acknowledges (drives SDA low in the ninth clock) an address byte whose bits 7..1 equal 1,1,0,0,0,addr_pins[1],addr_pins[0]. Bit 0 selects the direction: 0 = write, 1 = read. For any other address it never pulls SDA low and changes no output until the next START.
- R2: In a write transfer every complete data byte is acknowledged.
- R3: Divider byte A carries 0 in bit 7 and ratio bits 14..8 in bits 6..0. Divider byte B, which always follows A, carries ratio bits 7..0. div_ratio changes only when the acknowledge of byte B completes, and never after byte A alone.
- R4: A control byte carries 1 in bit 7, cp_sel in bit 6, test_mode in bits 5..4, ref_sel in bits 3..1 and osc_off in bit 0. These outputs update when its acknowledge completes.
- R5: The byte after a control byte is the band byte. Its bit 7 drives port_p7, bit 6 drives if_sel (0 selects IF output 1, 1 selects IF output 2), bit 5 drives port_p5, bit 4 drives port_p4 and bit 0 drives band_on (1 = on). Bits 3..1 are ignored.
- R6: The first data byte of a transfer, and any byte after a completed divider byte B or band byte, is decoded by its MSB: 0 means divider byte A and 1 means control byte.
- R7: A START or STOP before a byte's acknowledge completes discards that byte, together with a divider byte A still waiting for its byte B. Register outputs keep their previous values.
- R8: A read address is acknowledged. The status byte sent MSB first is {por, lock_i, cmp_i[2], cmp_i[1], cmp_i[0], 1, 1, 1}, sampled when the address acknowledge ends. A fresh byte follows each master acknowledge, and a master not-acknowledge ends the slave's activity.
- R9: The POR flag is 1 after reset and is set in every cycle in which supply_ok_i is 0. It clears only once a status byte has been completely sent while supply_ok_i is 1.
- R10: After reset, div_ratio and all control and band outputs are 0 and SDA is released.
- R11: A START or STOP releases SDA in the following cycle, and SDA drive changes only after a detected SCL fall, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pins | input | 2 | Strap bits for address bits 2..1 |
| lock_i | input | 1 | Loop lock indication |
| cmp_i | input | 3 | Comparator levels, reported as status bits 5..3 |
| supply_ok_i | input | 1 | Supply valid; 0 sets the POR flag |
| div_ratio | output | DIV_W | Active loop divider ratio |
| cp_sel | output | 1 | Charge-pump current select |
| test_mode | output | 2 | Test mode bits |
| ref_sel | output | 3 | Reference divider select |
| osc_off | output | 1 | Oscillator disable |
| port_p7 | output | 1 | Port output 7 |
| port_p5 | output | 1 | Port output 5 |
| port_p4 | output | 1 | Port output 4 |
| if_sel | output | 1 | IF output select, 0 = output 1 |
| band_on | output | 1 | Band output enable |

## Verification
The bench builds the block with a three-stage synchronizer instead of the default two, so every bus event is seen one cycle later. This shows that the frame decoding does not rely on a particular synchronizer depth, provided the bench's quarter-bit spacing exceeds the synchronizer latency. The divider width and address prefix stay at their defaults, so the full 15-bit ratio and both strap bits are used. Directed transfers cover both decoding orders (divider first and control first), a mismatched strap address, interruptions both inside a byte and between divider bytes, multi-byte reads, and reads taken while the supply is low.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } bus_state_t;

  typedef enum logic [1:0] {
    SL_ANY,
    SL_DIV_LO,
    SL_BAND
  } slot_t;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/tpll_line_sync.sv
module tpll_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;
  logic              scl_now;
  logic              sda_now;

  assign scl_now = scl_ff[STAGES-1];
  assign sda_now = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_now;
      sda_q  <= sda_now;
    end
  end

  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_now;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_now;
  assign sda_bit   = sda_now;

endmodule

// File: rtl/tpll_bus_engine.sv
module tpll_bus_engine
  import tpll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_bit,
  input  logic [6:0] dev_addr,
  input  logic [7:0] status_byte,
  output logic       sda_oe,
  output logic       wr_strobe,
  output logic [7:0] wr_byte,
  output logic       xfer_begin,
  output logic       status_sent
);

  localparam int CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_BITS);

  bus_state_t    state;
  logic [CW-1:0] cnt;
  logic [7:0]    shreg;
  logic          mack;

  assign wr_byte = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      mack        <= 1'b0;
      sda_oe      <= 1'b0;
      wr_strobe   <= 1'b0;
      xfer_begin  <= 1'b0;
      status_sent <= 1'b0;
    end else begin
      wr_strobe   <= 1'b0;
      xfer_begin  <= 1'b0;
      status_sent <= 1'b0;
      if (start_det) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        sda_oe     <= 1'b0;
        xfer_begin <= 1'b1;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[6:0], sda_bit};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_WDAT) begin
                state  <= ST_WACK;
                sda_oe <= 1'b1;
              end else if (shreg[7:1] == dev_addr) begin
                state  <= ST_AACK;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (shreg[0]) begin
                state  <= ST_RDAT;
                shreg  <= status_byte;
                sda_oe <= ~status_byte[7];
              end else begin
                state  <= ST_WDAT;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe    <= 1'b0;
              wr_strobe <= 1'b1;
              state     <= ST_WDAT;
              cnt       <= '0;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              sda_oe      <= 1'b0;
              status_sent <= 1'b1;
              state       <= ST_RACK;
            end else if (scl_fall && cnt != '0) begin
              shreg  <= {shreg[6:0], 1'b1};
              sda_oe <= ~shreg[6];
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_bit;
            end else if (scl_fall) begin
              if (mack) begin
                state  <= ST_RDAT;
                cnt    <= '0;
                shreg  <= status_byte;
                sda_oe <= ~status_byte[7];
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_IDLE, ST_SKIP: begin
            sda_oe <= 1'b0;
          end
          default: begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/tpll_reg_bank.sv
module tpll_reg_bank
  import tpll_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_begin,
  input  logic             wr_strobe,
  input  logic [7:0]       wr_byte,
  output logic [DIV_W-1:0] div_ratio,
  output logic             cp_sel,
  output logic [1:0]       test_mode,
  output logic [2:0]       ref_sel,
  output logic             osc_off,
  output logic             port_p7,
  output logic             port_p5,
  output logic             port_p4,
  output logic             if_sel,
  output logic             band_on
);

  localparam int HI_W = DIV_W - BYTE_BITS;

  slot_t           slot;
  logic [HI_W-1:0] div_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= SL_ANY;
      div_hi    <= '0;
      div_ratio <= '0;
      cp_sel    <= 1'b0;
      test_mode <= '0;
      ref_sel   <= '0;
      osc_off   <= 1'b0;
      port_p7   <= 1'b0;
      port_p5   <= 1'b0;
      port_p4   <= 1'b0;
      if_sel    <= 1'b0;
      band_on   <= 1'b0;
    end else if (xfer_begin) begin
      slot <= SL_ANY;
    end else if (wr_strobe) begin
      case (slot)
        SL_ANY: begin
          if (wr_byte[7]) begin
            cp_sel    <= wr_byte[6];
            test_mode <= wr_byte[5:4];
            ref_sel   <= wr_byte[3:1];
            osc_off   <= wr_byte[0];
            slot      <= SL_BAND;
          end else begin
            div_hi <= wr_byte[HI_W-1:0];
            slot   <= SL_DIV_LO;
          end
        end
        SL_DIV_LO: begin
          div_ratio <= {div_hi, wr_byte};
          slot      <= SL_ANY;
        end
        SL_BAND: begin
          port_p7 <= wr_byte[7];
          if_sel  <= wr_byte[6];
          port_p5 <= wr_byte[5];
          port_p4 <= wr_byte[4];
          band_on <= wr_byte[0];
          slot    <= SL_ANY;
        end
        default: slot <= SL_ANY;
      endcase
    end
  end

endmodule

// File: rtl/tpll_por_flag.sv
module tpll_por_flag (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic status_sent,
  output logic por
);

  always_ff @(posedge clk) begin
    if (rst)              por <= 1'b1;
    else if (!supply_ok)  por <= 1'b1;
    else if (status_sent) por <= 1'b0;
  end

endmodule

// File: rtl/tuner_ctl_slave.sv
module tuner_ctl_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter int         DIV_W       = 15,
  parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       addr_pins,
  input  logic             lock_i,
  input  logic [2:0]       cmp_i,
  input  logic             supply_ok_i,
  output logic [DIV_W-1:0] div_ratio,
  output logic             cp_sel,
  output logic [1:0]       test_mode,
  output logic [2:0]       ref_sel,
  output logic             osc_off,
  output logic             port_p7,
  output logic             port_p5,
  output logic             port_p4,
  output logic             if_sel,
  output logic             band_on
);

  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic       sda_bit;
  logic       wr_strobe;
  logic [7:0] wr_byte;
  logic       xfer_begin;
  logic       status_sent;
  logic       por_flag;
  logic [6:0] dev_addr;
  logic [7:0] status_byte;

  assign dev_addr    = {ADDR_PREFIX, addr_pins};
  assign status_byte = {por_flag, lock_i, cmp_i, 3'b111};

  tpll_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit)
  );

  tpll_bus_engine u_eng (
    .clk         (clk),
    .rst         (rst),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_bit     (sda_bit),
    .dev_addr    (dev_addr),
    .status_byte (status_byte),
    .sda_oe      (sda_oe),
    .wr_strobe   (wr_strobe),
    .wr_byte     (wr_byte),
    .xfer_begin  (xfer_begin),
    .status_sent (status_sent)
  );

  tpll_reg_bank #(.DIV_W(DIV_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .xfer_begin (xfer_begin),
    .wr_strobe  (wr_strobe),
    .wr_byte    (wr_byte),
    .div_ratio  (div_ratio),
    .cp_sel     (cp_sel),
    .test_mode  (test_mode),
    .ref_sel    (ref_sel),
    .osc_off    (osc_off),
    .port_p7    (port_p7),
    .port_p5    (port_p5),
    .port_p4    (port_p4),
    .if_sel     (if_sel),
    .band_on    (band_on)
  );

  tpll_por_flag u_por (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok_i),
    .status_sent (status_sent),
    .por         (por_flag)
  );

endmodule

// File: rtl/tpll_checker.sv
module tpll_checker #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             start_det,
  input logic             stop_det,
  input logic             scl_fall,
  input logic             sda_oe,
  input logic             wr_strobe,
  input logic [DIV_W-1:0] div_ratio,
  input logic [6:0]       ctrl_bits,
  input logic [4:0]       band_bits,
  input logic             por_flag,
  input logic             supply_ok,
  input logic             status_sent
);

  p_release_on_cond_r11: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> !sda_oe);

  p_oe_moves_on_event_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  p_div_at_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_ratio) |-> $past(wr_strobe));

  p_ctrl_at_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_bits) |-> $past(wr_strobe));

  p_band_at_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(band_bits) |-> $past(wr_strobe));

  p_por_set_r9: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> por_flag);

  p_por_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(por_flag) |-> ($past(status_sent) && $past(supply_ok)));

endmodule

bind tuner_ctl_slave tpll_checker #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .scl_fall    (scl_fall),
  .sda_oe      (sda_oe),
  .wr_strobe   (wr_strobe),
  .div_ratio   (div_ratio),
  .ctrl_bits   ({cp_sel, test_mode, ref_sel, osc_off}),
  .band_bits   ({port_p7, if_sel, port_p5, port_p4, band_on}),
  .por_flag    (por_flag),
  .supply_ok   (supply_ok_i),
  .status_sent (status_sent)
);

// File: tb/tb_tuner_ctl_slave.sv
`timescale 1ns/1ps
module tb_tuner_ctl_slave;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  addr_pins = 2'b10;
  logic        lock_i = 1'b0;
  logic [2:0]  cmp_i = 3'b000;
  logic        supply_ok_i = 1'b1;
  logic        sda_line;
  logic        sda_oe;
  logic [14:0] div_ratio;
  logic        cp_sel, osc_off, port_p7, port_p5, port_p4, if_sel, band_on;
  logic [1:0]  test_mode;
  logic [2:0]  ref_sel;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  tuner_ctl_slave #(.SYNC_STAGES(3)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(addr_pins), .lock_i(lock_i), .cmp_i(cmp_i),
    .supply_ok_i(supply_ok_i), .div_ratio(div_ratio), .cp_sel(cp_sel),
    .test_mode(test_mode), .ref_sel(ref_sel), .osc_off(osc_off),
    .port_p7(port_p7), .port_p5(port_p5), .port_p4(port_p4),
    .if_sel(if_sel), .band_on(band_on)
  );

  function automatic logic [6:0] ctrl_v();
    return {cp_sel, test_mode, ref_sel, osc_off};
  endfunction

  function automatic logic [4:0] band_v();
    return {port_p7, if_sel, port_p5, port_p4, band_on};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    ack = ~sda_line;
    qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] v);
    v = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qwait();
      scl_m = 1'b1; qwait();
      v = {v[6:0], sda_line};
      qwait();
      scl_m = 1'b0;
    end
    qwait();
    put_bit(~master_ack);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check("R10 div_ratio", 32'(div_ratio), 0);
    check("R10 control", 32'(ctrl_v()), 0);
    check("R10 band", 32'(band_v()), 0);
    check("R10 sda_oe", 32'(sda_oe), 0);
  endtask

  task automatic t_full_write();
    logic ack;
    bus_start();
    put_byte(8'hC4, ack); check("R1 address ack", 32'(ack), 1);
    put_byte(8'h35, ack); check("R2 div A ack", 32'(ack), 1);
    check("R3 ratio held after byte A", 32'(div_ratio), 0);
    put_byte(8'hA7, ack); check("R2 div B ack", 32'(ack), 1);
    check("R3 ratio", 32'(div_ratio), 32'h35A7);
    put_byte(8'hCB, ack); check("R2 control ack", 32'(ack), 1);
    check("R4 control fields", 32'(ctrl_v()), 32'h4B);
    put_byte(8'hD1, ack); check("R2 band ack", 32'(ack), 1);
    check("R5 band fields", 32'(band_v()), 32'h1B);
    bus_stop();
  endtask

  task automatic t_ctrl_first();
    logic ack;
    bus_start();
    put_byte(8'hC4, ack);
    put_byte(8'hB4, ack);
    check("R6 control first", 32'(ctrl_v()), 32'h34);
    check("R6 ratio untouched", 32'(div_ratio), 32'h35A7);
    put_byte(8'h2E, ack);
    check("R5 band with ignored bits", 32'(band_v()), 32'h04);
    put_byte(8'h12, ack);
    put_byte(8'h34, ack);
    check("R6 divider after band", 32'(div_ratio), 32'h1234);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    put_byte(8'hC2, ack); check("R1 wrong strap no ack", 32'(ack), 0);
    put_byte(8'h00, ack); check("R1 ignored byte no ack", 32'(ack), 0);
    put_byte(8'h55, ack);
    check("R1 ratio unchanged", 32'(div_ratio), 32'h1234);
    bus_stop();
    bus_start();
    put_byte(8'h44, ack); check("R1 wrong prefix no ack", 32'(ack), 0);
    put_byte(8'hFF, ack);
    check("R1 control unchanged", 32'(ctrl_v()), 32'h34);
    bus_stop();
  endtask

  task automatic t_abort();
    logic ack;
    bus_start();
    put_byte(8'hC4, ack);
    put_byte(8'h7F, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    check("R7 stop mid byte", 32'(div_ratio), 32'h1234);
    bus_start();
    put_byte(8'hC4, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    bus_start();
    put_byte(8'hC4, ack);
    check("R7 restart ack", 32'(ack), 1);
    bus_stop();
    check("R7 start mid byte", 32'(ctrl_v()), 32'h34);
    bus_start();
    put_byte(8'hC4, ack);
    put_byte(8'h01, ack);
    bus_stop();
    bus_start();
    put_byte(8'hC4, ack);
    put_byte(8'h56, ack);
    put_byte(8'h78, ack);
    bus_stop();
    check("R7 pending byte A dropped", 32'(div_ratio), 32'h5678);
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] v;
    lock_i = 1'b1; cmp_i = 3'b101;
    bus_start();
    put_byte(8'hC5, ack); check("R8 read address ack", 32'(ack), 1);
    get_byte(1'b0, v); check("R8 status with por", 32'(v), 32'hEF);
    bus_stop();
    bus_start();
    put_byte(8'hC5, ack);
    get_byte(1'b0, v); check("R9 por cleared", 32'(v), 32'h6F);
    bus_stop();
    lock_i = 1'b0; cmp_i = 3'b010;
    bus_start();
    put_byte(8'hC5, ack);
    get_byte(1'b1, v); check("R8 first of two", 32'(v), 32'h17);
    get_byte(1'b0, v); check("R8 second of two", 32'(v), 32'h17);
    bus_stop();
  endtask

  task automatic t_por_supply();
    logic ack;
    logic [7:0] v;
    lock_i = 1'b1; cmp_i = 3'b000;
    supply_ok_i = 1'b0;
    bus_start();
    put_byte(8'hC5, ack);
    get_byte(1'b0, v); check("R9 por during low supply", 32'(v), 32'hC7);
    bus_stop();
    supply_ok_i = 1'b1;
    bus_start();
    put_byte(8'hC5, ack);
    get_byte(1'b0, v); check("R9 por kept after low read", 32'(v), 32'hC7);
    bus_stop();
    bus_start();
    put_byte(8'hC5, ack);
    get_byte(1'b0, v); check("R9 por cleared after valid read", 32'(v), 32'h47);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_full_write();
    t_ctrl_first();
    t_mismatch();
    t_abort();
    t_read();
    t_por_supply();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule